// File: doc/BRIEF.md
# Power-Management Event Logger with Interrupt Routing

The block sits at a downstream port and takes in power-management event messages. Each message is a one-cycle strobe that carries a 16-bit requester ID. The block keeps a log that is two entries deep.

The first message sets a pending flag and exposes its ID in the status register. A message that arrives while an event is already pending sets an overflow flag. Its ID goes into a holding register that software cannot see. When software clears the pending flag, the held ID moves up into the visible field and the pending flag comes back on. The block treats that promotion as a new event.

Each newly logged event is routed according to the enables:
- With the interrupt enable on, the event produces an interrupt. With MSI enabled this is a one-cycle MSI request pulse. Otherwise it is a level pin that stays high while the pending flag and the enable are both on.
- With the interrupt enable off, the event produces a one-cycle GPE request pulse to the power-management controller instead.
- Two separately enabled status bits record the event for SCI and for SMI. The SMI status bit also drives the SMI output.
- Turning the interrupt enable from 0 to 1 while an event is pending also raises an interrupt.

The log is a three-state machine.

| State | Meaning |
|---|---|
| LOG_IDLE | Nothing is pending. |
| LOG_ONE | One event is pending and visible. |
| LOG_TWO | One event is visible and a second ID is held. |

| Transition | From | To | Cause |
|---|---|---|---|
| first-log | LOG_IDLE | LOG_ONE | A message arrives. |
| relog | LOG_ONE | LOG_ONE | Pending is cleared in the same cycle a message arrives. |
| drain | LOG_ONE | LOG_IDLE | Pending is cleared. |
| hold | LOG_ONE | LOG_TWO | A message arrives. |
| promote | LOG_TWO | LOG_ONE | Pending is cleared. |
| promote-and-hold | LOG_TWO | LOG_TWO | Pending is cleared while a message arrives. |
| drop | LOG_TWO | LOG_ONE | Only the overflow flag is cleared. |
| overwrite | LOG_TWO | LOG_TWO | A further message arrives and replaces the held ID. |

The register port is a simple one.
- Writes take effect at the clock edge.
- Reads are combinational on `reg_addr`.

| Address | Contents |
|---|---|
| 0 | Status |
| 1 | Interrupt control |
| 2 | MSI control |
| 3 | Route enables |
| 4 | SCI/SMI status |

All outputs are registered. Their effect appears one cycle after the input edge that caused it.

Top module: `pme_event_log`

## Requirements
- R1: After reset:
  - every status bit reads 0 and the held slot is empty;
  - all enables are 0;
  - `irq_pin`, `msi_pulse`, `gpe_pulse` and `smi_out` are low.
- R2: A message that arrives with the pending flag clear does two things:
  - it sets the pending flag (status bit 16);
  - it places its ID in status bits 15:0.
- R3: A message that arrives while the pending flag is set sets the overflow flag (status bit 17) and keeps its ID only in the held slot. The visible ID is unchanged. No interrupt, MSI, GPE, SCI or SMI action results.
- R4: Writing 1 to status bit 16 while an ID is held has three effects:
  - the held ID moves to bits 15:0;
  - the overflow flag clears;
  - the pending flag stays set, and this counts as a new event.
- R5: Writing 1 to status bit 16 in the same cycle a message arrives, with nothing held, logs that message as a fresh first event. The overflow flag stays clear.
- R6: Both status registers behave as follows:
  - their bits are write-one-to-clear, and writing 0 leaves them unchanged;
  - writes to status bits 15:0 are ignored.
- R7: When a new event occurs with the interrupt enable on (address 1 bit 3):
  - if MSI enable (address 2 bit 0) is set, `msi_pulse` is high for exactly one cycle;
  - if MSI enable is clear, `irq_pin` is high for as long as the pending flag and the interrupt enable stay set.
  - Setting MSI enable drops the pin.
- R8: A new event with the interrupt enable off gives exactly one cycle of `gpe_pulse`.
- R9: Writing the interrupt enable from 0 to 1 while the pending flag is set raises an interrupt: an MSI pulse when MSI is enabled, the pin otherwise.
- R10: With the SCI enable (address 3 bit 1) set, a new event sets bit 31 of address 4.
- R11: With the SMI enable (address 3 bit 0) set, a new event sets bit 0 of address 4 and drives `smi_out` high. This happens regardless of the interrupt and SCI paths.
- R12: Writing 1 to status bit 17 alone, while an ID is held, discards the held ID. A later clear of the pending flag then leaves the log empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | One-cycle strobe: an event message is present |
| msg_id | input | 16 | Requester ID of the message |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq_pin | output | 1 | Level interrupt |
| msi_pulse | output | 1 | One-cycle MSI request |
| gpe_pulse | output | 1 | One-cycle GPE request |
| smi_out | output | 1 | SMI, driven from the SMI status bit |

## Verification
The bench drives the two-deep log through promotion, relog, overflow overwrite and drop of the held ID.
- A design that forgot the held ID would read back a stale or zero ID after the pending flag is cleared.
- A design that treated a held message as an event would emit a spurious pulse.
- A design that dropped the message arriving in the same cycle as a clear would return to an empty log.

It also toggles the interrupt enable while an event is pending. An implementation that fires only on message arrival would miss that MSI. It checks that SMI status is recorded with the interrupt path on, that SMI status clears on a write of one, and that writes to the ID field leave it unchanged.

// File: rtl/pme_pkg.sv
package pme_pkg;
    typedef enum logic [1:0] {
        LOG_IDLE = 2'd0,
        LOG_ONE  = 2'd1,
        LOG_TWO  = 2'd2
    } log_state_e;

    localparam int unsigned ADDR_W     = 3;
    localparam logic [ADDR_W-1:0] REG_STATUS = 3'd0;
    localparam logic [ADDR_W-1:0] REG_INTC   = 3'd1;
    localparam logic [ADDR_W-1:0] REG_MSIC   = 3'd2;
    localparam logic [ADDR_W-1:0] REG_ROUTE  = 3'd3;
    localparam logic [ADDR_W-1:0] REG_RSTS   = 3'd4;

    localparam int unsigned IE_BIT     = 3;
    localparam int unsigned MSIE_BIT   = 0;
    localparam int unsigned SMI_EN_BIT = 0;
    localparam int unsigned SCI_EN_BIT = 1;
    localparam int unsigned SMI_ST_BIT = 0;
endpackage

// File: rtl/pme_log_fsm.sv
module pme_log_fsm
    import pme_pkg::*;
#(
    parameter int unsigned ID_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            msg_valid,
    input  logic [ID_W-1:0] msg_id,
    input  logic            clr_pend,
    input  logic            clr_ovf,
    output logic            pending,
    output logic            overflow,
    output logic [ID_W-1:0] vis_id,
    output logic            log_event
);
    log_state_e      state_q, state_d;
    logic [ID_W-1:0] vis_q, vis_d;
    logic [ID_W-1:0] held_q, held_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LOG_IDLE;
            vis_q   <= '0;
            held_q  <= '0;
        end else begin
            state_q <= state_d;
            vis_q   <= vis_d;
            held_q  <= held_d;
        end
    end

    // next state and event detection
    always_comb begin
        state_d   = state_q;
        vis_d     = vis_q;
        held_d    = held_q;
        log_event = 1'b0;
        unique case (state_q)
            LOG_IDLE: begin
                if (msg_valid) begin          // first-log
                    state_d   = LOG_ONE;
                    vis_d     = msg_id;
                    log_event = 1'b1;
                end
            end
            LOG_ONE: begin
                if (clr_pend && msg_valid) begin   // relog
                    vis_d     = msg_id;
                    log_event = 1'b1;
                end else if (clr_pend) begin       // drain
                    state_d = LOG_IDLE;
                    vis_d   = '0;
                end else if (msg_valid) begin      // hold
                    state_d = LOG_TWO;
                    held_d  = msg_id;
                end
            end
            LOG_TWO: begin
                if (clr_pend) begin
                    vis_d     = held_q;
                    log_event = 1'b1;
                    if (msg_valid) begin           // promote-and-hold
                        held_d = msg_id;
                    end else begin                 // promote
                        state_d = LOG_ONE;
                    end
                end else if (clr_ovf && !msg_valid) begin  // drop
                    state_d = LOG_ONE;
                end else if (msg_valid) begin      // overwrite
                    held_d = msg_id;
                end
            end
            default: begin
                state_d = LOG_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        pending  = (state_q != LOG_IDLE);
        overflow = (state_q == LOG_TWO);
        vis_id   = vis_q;
    end

    AST_FIRST_LOG: assert property (@(posedge clk) disable iff (!rst_n)
        (!pending && msg_valid) |=> (pending && !overflow && vis_id == $past(msg_id))); // R2
    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !overflow && msg_valid && !clr_pend) |=> (overflow && $stable(vis_id))); // R3
    AST_PROMOTE: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && clr_pend) |=> (pending && vis_id == $past(held_q))); // R4
    AST_RELOG: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !overflow && clr_pend && msg_valid) |=> (pending && !overflow && vis_id == $past(msg_id))); // R5
endmodule

// File: rtl/pme_ctrl_regs.sv
module pme_ctrl_regs
    import pme_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              log_event,
    output logic              ie,
    output logic              msie,
    output logic              smi_en,
    output logic              sci_en,
    output logic              sci_sts,
    output logic              smi_sts,
    output logic              ie_rise
);
    localparam int unsigned SCI_ST_BIT = DATA_W - 1;

    logic ie_q, msie_q, smi_en_q, sci_en_q, sci_q, smi_q;
    logic wr_intc, wr_msic, wr_route, wr_rsts;
    logic unused_wbits;

    assign unused_wbits = ^reg_wdata;

    always_comb begin
        wr_intc  = reg_wr && (reg_addr == REG_INTC);
        wr_msic  = reg_wr && (reg_addr == REG_MSIC);
        wr_route = reg_wr && (reg_addr == REG_ROUTE);
        wr_rsts  = reg_wr && (reg_addr == REG_RSTS);
        ie_rise  = wr_intc && reg_wdata[IE_BIT] && !ie_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q     <= 1'b0;
            msie_q   <= 1'b0;
            smi_en_q <= 1'b0;
            sci_en_q <= 1'b0;
            sci_q    <= 1'b0;
            smi_q    <= 1'b0;
        end else begin
            if (wr_intc)  ie_q   <= reg_wdata[IE_BIT];
            if (wr_msic)  msie_q <= reg_wdata[MSIE_BIT];
            if (wr_route) begin
                smi_en_q <= reg_wdata[SMI_EN_BIT];
                sci_en_q <= reg_wdata[SCI_EN_BIT];
            end
            sci_q <= (sci_q && !(wr_rsts && reg_wdata[SCI_ST_BIT])) || (log_event && sci_en_q);
            smi_q <= (smi_q && !(wr_rsts && reg_wdata[SMI_ST_BIT])) || (log_event && smi_en_q);
        end
    end

    always_comb begin
        ie      = ie_q;
        msie    = msie_q;
        smi_en  = smi_en_q;
        sci_en  = sci_en_q;
        sci_sts = sci_q;
        smi_sts = smi_q;
    end

    AST_SCI_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (log_event && sci_en) |=> sci_sts); // R10
    AST_SMI_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (log_event && smi_en) |=> smi_sts); // R11
    AST_SMI_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (!log_event && wr_rsts && reg_wdata[SMI_ST_BIT]) |=> !smi_sts); // R6
endmodule

// File: rtl/pme_irq_out.sv
module pme_irq_out (
    input  logic clk,
    input  logic rst_n,
    input  logic log_event,
    input  logic pending,
    input  logic ie,
    input  logic msie,
    input  logic ie_rise,
    output logic irq_pin,
    output logic msi_pulse,
    output logic gpe_pulse
);
    logic msi_q, gpe_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msi_q <= 1'b0;
            gpe_q <= 1'b0;
        end else begin
            msi_q <= msie && ((ie && log_event) || (ie_rise && pending));
            gpe_q <= log_event && !ie;
        end
    end

    always_comb begin
        irq_pin   = pending && ie && !msie;
        msi_pulse = msi_q;
        gpe_pulse = gpe_q;
    end

    AST_MSI_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        (log_event && ie && msie) |=> msi_pulse); // R7
    AST_GPE_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        (log_event && !ie) |=> gpe_pulse); // R8
    AST_IE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (ie_rise && pending && msie) |=> msi_pulse); // R9
    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({msi_pulse, gpe_pulse})); // R8
endmodule

// File: rtl/pme_event_log.sv
module pme_event_log
    import pme_pkg::*;
#(
    parameter int unsigned ID_W   = 16,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msg_valid,
    input  logic [ID_W-1:0]   msg_id,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_pin,
    output logic              msi_pulse,
    output logic              gpe_pulse,
    output logic              smi_out
);
    localparam int unsigned PEND_BIT   = ID_W;
    localparam int unsigned OVF_BIT    = ID_W + 1;
    localparam int unsigned SCI_ST_BIT = DATA_W - 1;

    logic            clr_pend, clr_ovf;
    logic            pending, overflow, log_event;
    logic [ID_W-1:0] vis_id;
    logic            ie, msie, smi_en, sci_en, sci_sts, smi_sts, ie_rise;

    always_comb begin
        clr_pend = reg_wr && (reg_addr == REG_STATUS) && reg_wdata[PEND_BIT];
        clr_ovf  = reg_wr && (reg_addr == REG_STATUS) && reg_wdata[OVF_BIT];
    end

    pme_log_fsm #(.ID_W(ID_W)) u_log (
        .clk       (clk),
        .rst_n     (rst_n),
        .msg_valid (msg_valid),
        .msg_id    (msg_id),
        .clr_pend  (clr_pend),
        .clr_ovf   (clr_ovf),
        .pending   (pending),
        .overflow  (overflow),
        .vis_id    (vis_id),
        .log_event (log_event)
    );

    pme_ctrl_regs #(.DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .log_event (log_event),
        .ie        (ie),
        .msie      (msie),
        .smi_en    (smi_en),
        .sci_en    (sci_en),
        .sci_sts   (sci_sts),
        .smi_sts   (smi_sts),
        .ie_rise   (ie_rise)
    );

    pme_irq_out u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .log_event (log_event),
        .pending   (pending),
        .ie        (ie),
        .msie      (msie),
        .ie_rise   (ie_rise),
        .irq_pin   (irq_pin),
        .msi_pulse (msi_pulse),
        .gpe_pulse (gpe_pulse)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            REG_STATUS: begin
                reg_rdata[ID_W-1:0] = vis_id;
                reg_rdata[PEND_BIT] = pending;
                reg_rdata[OVF_BIT]  = overflow;
            end
            REG_INTC:  reg_rdata[IE_BIT] = ie;
            REG_MSIC:  reg_rdata[MSIE_BIT] = msie;
            REG_ROUTE: begin
                reg_rdata[SMI_EN_BIT] = smi_en;
                reg_rdata[SCI_EN_BIT] = sci_en;
            end
            REG_RSTS: begin
                reg_rdata[SCI_ST_BIT] = sci_sts;
                reg_rdata[SMI_ST_BIT] = smi_sts;
            end
            default: reg_rdata = '0;
        endcase
        smi_out = smi_sts;
    end

    AST_OVF_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[OVF_BIT] && reg_addr == REG_STATUS) |-> reg_rdata[PEND_BIT]); // R3
endmodule

// File: tb/pme_event_log_tb_top.sv
module pme_event_log_tb_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        msg_valid = 1'b0;
    logic [15:0] msg_id = '0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_pin, msi_pulse, gpe_pulse, smi_out;

    int cyc = 0;
    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        int          due;
        bit          is_reg;
        logic [31:0] exp;
        string       req;
    } item_t;
    item_t sb[$];

    always #(CLK_P/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pme_event_log dut_i (
        .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_id(msg_id),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_pin(irq_pin), .msi_pulse(msi_pulse),
        .gpe_pulse(gpe_pulse), .smi_out(smi_out)
    );

    // monitor: compare items due this cycle, a quarter period after the edge
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_P/4);
            while (sb.size() > 0 && sb[0].due <= cyc) begin
                item_t it;
                logic [31:0] got;
                it = sb.pop_front();
                got = it.is_reg ? reg_rdata : {28'd0, irq_pin, msi_pulse, gpe_pulse, smi_out};
                n_checks++;
                if (got !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: got %h expected %h (cycle %0d)", it.req, got, it.exp, cyc);
                end
            end
        end
    end

    task automatic drive(input logic mv, input logic [15:0] id, input logic wr,
                         input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        msg_valid = mv; msg_id = id; reg_wr = wr; reg_addr = a; reg_wdata = d;
    endtask

    // outputs vector {irq_pin, msi_pulse, gpe_pulse, smi_out}
    task automatic exp_out(input string req, input logic [3:0] e);
        item_t it;
        it.due = cyc + 1; it.is_reg = 1'b0; it.exp = {28'd0, e}; it.req = req;
        sb.push_back(it);
    endtask

    task automatic rd(input logic [2:0] a, input logic [31:0] e, input string req);
        item_t it;
        drive(1'b0, 16'h0, 1'b0, a, 32'h0);
        it.due = cyc + 1; it.is_reg = 1'b1; it.exp = e; it.req = req;
        sb.push_back(it);
    endtask

    task automatic msg(input logic [15:0] id);
        drive(1'b1, id, 1'b0, 3'd0, 32'h0);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        drive(1'b0, 16'h0, 1'b1, a, d);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(3'd0, 32'h0, "R1 status");
        exp_out("R1 outputs", 4'b0000);
        rd(3'd4, 32'h0, "R1 sci/smi status");
        // R2 / R8 first event, interrupts off -> GPE pulse
        msg(16'h1234);           exp_out("R8 gpe pulse", 4'b0010);
        rd(3'd0, 32'h0001_1234, "R2 status");
        exp_out("R8 single pulse", 4'b0000);
        // R3 second message is held only
        msg(16'hBEEF);           exp_out("R3 no action", 4'b0000);
        rd(3'd0, 32'h0003_1234, "R3 status");
        // R6 write to ID field and zero in flags ignored
        wr(3'd0, 32'h0000_FFFF);
        rd(3'd0, 32'h0003_1234, "R6 id write ignored");
        // R4 promote
        wr(3'd0, 32'h0001_0000); exp_out("R4 promote event gpe", 4'b0010);
        rd(3'd0, 32'h0001_BEEF, "R4 status");
        // R5 clear with simultaneous message, nothing held
        drive(1'b1, 16'h5555, 1'b1, 3'd0, 32'h0001_0000);
        exp_out("R5 fresh event gpe", 4'b0010);
        rd(3'd0, 32'h0001_5555, "R5 status");
        // enable SMI and SCI, then R9 enable rise with pin
        wr(3'd3, 32'h0000_0003);
        wr(3'd1, 32'h0000_0008); exp_out("R9 pin rises", 4'b1000);
        rd(3'd4, 32'h0, "R10 no event yet");
        // R3 hold with routes enabled: no SMI
        msg(16'h7777);           exp_out("R3 held no smi", 4'b1000);
        // R10 R11 promote with interrupt path on
        wr(3'd0, 32'h0001_0000); exp_out("R11 smi with pin", 4'b1001);
        rd(3'd0, 32'h0001_7777, "R4 second promote");
        rd(3'd4, 32'h8000_0001, "R10 sci and smi status");
        // R6 W1C of route status
        wr(3'd4, 32'h8000_0001); exp_out("R6 smi cleared", 4'b1000);
        rd(3'd4, 32'h0, "R6 route status cleared");
        // R7 MSI enable drops pin
        wr(3'd2, 32'h0000_0001); exp_out("R7 pin off with msi", 4'b0000);
        wr(3'd0, 32'h0001_0000);
        rd(3'd0, 32'h0, "R6 drain to empty");
        msg(16'h0ABC);           exp_out("R7 msi pulse", 4'b0101);
        drive(1'b0, 16'h0, 1'b0, 3'd0, 32'h0);
        exp_out("R7 msi single cycle", 4'b0001);
        // R9 toggle enable with MSI
        wr(3'd1, 32'h0);         exp_out("R9 enable off", 4'b0001);
        wr(3'd1, 32'h0000_0008); exp_out("R9 msi on enable rise", 4'b0101);
        drive(1'b0, 16'h0, 1'b0, 3'd0, 32'h0);
        exp_out("R9 msi single cycle", 4'b0001);
        // R12 drop held
        msg(16'h1111);
        rd(3'd0, 32'h0003_0ABC, "R12 held");
        wr(3'd0, 32'h0002_0000);
        rd(3'd0, 32'h0001_0ABC, "R12 overflow dropped");
        wr(3'd0, 32'h0001_0000); exp_out("R12 no event", 4'b0001);
        rd(3'd0, 32'h0, "R12 empty after clear");
        msg(16'h2222);
        rd(3'd0, 32'h0001_2222, "R12 new first event");
        repeat (4) drive(1'b0, 16'h0, 1'b0, 3'd0, 32'h0);
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule